// File: doc/BRIEF.md
# Ping-Pong Serial DMA Channel Controller

This block sequences the transmit and receive DMA channels of one serial port. Each direction owns two buffers, A and B. Each buffer is described by an inclusive start and end byte address that the surrounding register file supplies. Software writes a six-bit control word. Some bits arm a buffer and some reset a whole direction. Reading the word back shows which buffers are still active or waiting. An arm bit drops by itself when its buffer has been fully moved. At that moment a one-cycle done pulse is raised for that buffer, for use as an interrupt source.

The transmit channel fetches bytes from memory and offers them on a byte stream with a valid/ready handshake. The receive channel accepts bytes from a stream and writes them to memory. Both channels share a single memory port. A request is accepted in the cycle its grant is high, and read data is valid in that same cycle. Receive requests take precedence over transmit requests. While one buffer runs, software can arm the other one. The channel then moves from buffer to buffer without software having to wait for each buffer to finish.

Top module: `serial_dma_ctrl`

## Requirements
- R1: After reset the control read value is zero. Bits 31:4 always read zero, so the two reset bits (bit 5 transmit, bit 4 receive) are write-only. The status bits are: bit 0 receive A, bit 1 receive B, bit 2 transmit A, bit 3 transmit B.
- R2: Writing 1 to the arm bit of an idle buffer sets its status bit, and the read value shows it from the next cycle. Writing 0 to an arm bit leaves that bit unchanged.
- R3: A buffer completes when the byte at its end address moves. At that point its status bit clears and its done output (index 0 = A, 1 = B) is high for exactly one cycle.
- R4: When buffers A and B of one direction are armed in the same write, all of A is processed before any of B.
- R5: The transmit channel reads a buffer's addresses from start to end, in ascending order, and presents each byte on the transmit stream in that order.
- R6: The receive channel writes the stream bytes it accepts to a buffer's addresses, from start to end, in ascending order.
- R7: If the other buffer is armed when a buffer completes, the channel stays active and starts that buffer with no idle cycle. Otherwise the channel goes idle until something is armed.
- R8: Arming a buffer that is already active has no effect, and the buffer runs only once. Arming an idle buffer while the other buffer is active queues it behind the active one.
- R9: A direction reset clears both of that direction's arm bits, discards any byte in flight and stops its stream handshake. It leaves the other direction untouched. A reset bit wins over arm bits written for the same direction in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 6 | Control write data (arm and reset bits) |
| ctrl_rdata_o | output | 32 | Control read value (buffer status) |
| tx_a_beg_i | input | AW | Transmit buffer A start address |
| tx_a_end_i | input | AW | Transmit buffer A end address (inclusive) |
| tx_b_beg_i | input | AW | Transmit buffer B start address |
| tx_b_end_i | input | AW | Transmit buffer B end address (inclusive) |
| rx_a_beg_i | input | AW | Receive buffer A start address |
| rx_a_end_i | input | AW | Receive buffer A end address (inclusive) |
| rx_b_beg_i | input | AW | Receive buffer B start address |
| rx_b_end_i | input | AW | Receive buffer B end address (inclusive) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_gnt_i | input | 1 | Memory grant, same cycle |
| mem_rdata_i | input | 8 | Memory read data, valid with grant |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Transmit byte accepted |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Receive byte can be accepted |
| tx_done_o | output | 2 | Transmit buffer done pulses (0 = A, 1 = B) |
| rx_done_o | output | 2 | Receive buffer done pulses (0 = A, 1 = B) |

## Verification
Several arming patterns are used, each to expose a different fault:
- A single buffer on its own tests the address walk and the end-inclusive stop.
- Both buffers armed in one write exposes a reversed priority.
- Arming B while A is running separates queueing from dropping the request.
- A repeat arm and a zero write while a buffer is stalled show whether a buffer can run twice, or whether a zero write can clear status.

Memory grants and transmit ready are throttled in some runs, so that ordering is checked against irregular timing. Finally, each direction is reset halfway through a transfer while the other direction holds pending work. This shows whether the reset leaks across directions and whether the pointer restarts from the buffer's start address.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  // control word bit positions
  localparam int unsigned CB_RX_A   = 0;
  localparam int unsigned CB_RX_B   = 1;
  localparam int unsigned CB_TX_A   = 2;
  localparam int unsigned CB_TX_B   = 3;
  localparam int unsigned CB_RX_RST = 4;
  localparam int unsigned CB_TX_RST = 5;
  localparam int unsigned CW        = 6;
  localparam int unsigned RW        = 32;
  localparam logic BUF_A = 1'b0;
  localparam logic BUF_B = 1'b1;
endpackage

// File: rtl/sdma_seq.sv
module sdma_seq #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic [1:0]    arm_i,
  input  logic [AW-1:0] beg_a_i,
  input  logic [AW-1:0] end_a_i,
  input  logic [AW-1:0] beg_b_i,
  input  logic [AW-1:0] end_b_i,
  input  logic          beat_i,
  output logic          act_o,
  output logic [AW-1:0] ptr_o,
  output logic [1:0]    armed_o,
  output logic [1:0]    done_o
);
  import sdma_pkg::*;

  logic          act_q, cur_q;
  logic [AW-1:0] ptr_q, end_q;
  logic [1:0]    armed_q, done_q;
  logic [1:0]    armed_set, armed_clr, armed_nxt;
  logic          last, other, pick;

  assign armed_set = arm_i & ~armed_q;  // arming a live buffer is ignored
  assign last      = act_q && beat_i && (ptr_q == end_q);
  assign armed_clr = last ? (cur_q == BUF_A ? 2'b01 : 2'b10) : 2'b00;
  assign armed_nxt = (armed_q & ~armed_clr) | armed_set;
  assign other     = ~cur_q;
  assign pick      = armed_q[0] ? BUF_A : BUF_B;  // A wins

  function automatic logic [AW-1:0] beg_of(input logic b);
    return (b == BUF_A) ? beg_a_i : beg_b_i;
  endfunction
  function automatic logic [AW-1:0] end_of(input logic b);
    return (b == BUF_A) ? end_a_i : end_b_i;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      cur_q   <= BUF_A;
      ptr_q   <= '0;
      end_q   <= '0;
      armed_q <= '0;
      done_q  <= '0;
    end else if (soft_rst_i) begin
      act_q   <= 1'b0;
      cur_q   <= BUF_A;
      ptr_q   <= '0;
      end_q   <= '0;
      armed_q <= '0;
      done_q  <= '0;
    end else begin
      armed_q <= armed_nxt;
      done_q  <= armed_clr;
      if (act_q) begin
        if (last) begin
          if (armed_nxt[other]) begin
            cur_q <= other;
            ptr_q <= beg_of(other);
            end_q <= end_of(other);
          end else begin
            act_q <= 1'b0;
          end
        end else if (beat_i) begin
          ptr_q <= ptr_q + 1'b1;
        end
      end else if (|armed_q) begin
        act_q <= 1'b1;
        cur_q <= pick;
        ptr_q <= beg_of(pick);
        end_q <= end_of(pick);
      end
    end
  end

  assign act_o   = act_q;
  assign ptr_o   = ptr_q;
  assign armed_o = armed_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sdma_tx_path.sv
module sdma_tx_path #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          act_i,
  output logic          req_o,
  input  logic          gnt_i,
  input  logic [DW-1:0] rdata_i,
  output logic          beat_o,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  input  logic          ready_i
);
  logic          hold_v_q;
  logic [DW-1:0] hold_d_q;

  assign req_o  = act_i && !hold_v_q;
  assign beat_o = req_o && gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_d_q <= '0;
    end else if (flush_i) begin
      hold_v_q <= 1'b0;
    end else if (beat_o) begin
      hold_v_q <= 1'b1;
      hold_d_q <= rdata_i;
    end else if (hold_v_q && ready_i) begin
      hold_v_q <= 1'b0;
    end
  end

  assign valid_o = hold_v_q;
  assign data_o  = hold_d_q;
endmodule

// File: rtl/sdma_rx_path.sv
module sdma_rx_path #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          act_i,
  output logic          req_o,
  input  logic          gnt_i,
  output logic [DW-1:0] wdata_o,
  output logic          beat_o,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic          ready_o
);
  logic          hold_v_q;
  logic [DW-1:0] hold_d_q;

  assign ready_o = act_i && !hold_v_q;
  assign req_o   = hold_v_q;
  assign beat_o  = req_o && gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_d_q <= '0;
    end else if (flush_i) begin
      hold_v_q <= 1'b0;
    end else if (valid_i && ready_o) begin
      hold_v_q <= 1'b1;
      hold_d_q <= data_i;
    end else if (beat_o) begin
      hold_v_q <= 1'b0;
    end
  end

  assign wdata_o = hold_d_q;
endmodule

// File: rtl/sdma_mem_arb.sv
module sdma_mem_arb #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          rx_req_i,
  input  logic [AW-1:0] rx_addr_i,
  input  logic [DW-1:0] rx_wdata_i,
  output logic          rx_gnt_o,
  input  logic          tx_req_i,
  input  logic [AW-1:0] tx_addr_i,
  output logic          tx_gnt_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i
);
  // receive first: the line cannot be paused, transmit can
  assign mem_req_o   = rx_req_i || tx_req_i;
  assign mem_we_o    = rx_req_i;
  assign mem_addr_o  = rx_req_i ? rx_addr_i : tx_addr_i;
  assign mem_wdata_o = rx_wdata_i;
  assign rx_gnt_o    = mem_gnt_i && rx_req_i;
  assign tx_gnt_o    = mem_gnt_i && tx_req_i && !rx_req_i;
endmodule

// File: rtl/serial_dma_ctrl.sv
module serial_dma_ctrl #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [5:0]    ctrl_wdata_i,
  output logic [31:0]   ctrl_rdata_o,
  input  logic [AW-1:0] tx_a_beg_i,
  input  logic [AW-1:0] tx_a_end_i,
  input  logic [AW-1:0] tx_b_beg_i,
  input  logic [AW-1:0] tx_b_end_i,
  input  logic [AW-1:0] rx_a_beg_i,
  input  logic [AW-1:0] rx_a_end_i,
  input  logic [AW-1:0] rx_b_beg_i,
  input  logic [AW-1:0] rx_b_end_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_ready_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          rx_ready_o,
  output logic [1:0]    tx_done_o,
  output logic [1:0]    rx_done_o
);
  import sdma_pkg::*;

  localparam int unsigned PADW = RW - 4;

  logic          tx_rst, rx_rst;
  logic [1:0]    tx_arm, rx_arm, tx_armed, rx_armed;
  logic          tx_act, rx_act, tx_req, rx_req, tx_gnt, rx_gnt, tx_beat, rx_beat;
  logic [AW-1:0] tx_ptr, rx_ptr;
  logic [DW-1:0] rx_wdata;

  assign tx_rst = ctrl_we_i && ctrl_wdata_i[CB_TX_RST];
  assign rx_rst = ctrl_we_i && ctrl_wdata_i[CB_RX_RST];
  assign tx_arm = ctrl_we_i ? {ctrl_wdata_i[CB_TX_B], ctrl_wdata_i[CB_TX_A]} : 2'b00;
  assign rx_arm = ctrl_we_i ? {ctrl_wdata_i[CB_RX_B], ctrl_wdata_i[CB_RX_A]} : 2'b00;

  assign ctrl_rdata_o = {{PADW{1'b0}}, tx_armed, rx_armed};

  sdma_seq #(.AW(AW)) i_tx_seq (
    .clk_i, .rst_ni, .soft_rst_i(tx_rst), .arm_i(tx_arm),
    .beg_a_i(tx_a_beg_i), .end_a_i(tx_a_end_i), .beg_b_i(tx_b_beg_i), .end_b_i(tx_b_end_i),
    .beat_i(tx_beat), .act_o(tx_act), .ptr_o(tx_ptr), .armed_o(tx_armed), .done_o(tx_done_o)
  );

  sdma_seq #(.AW(AW)) i_rx_seq (
    .clk_i, .rst_ni, .soft_rst_i(rx_rst), .arm_i(rx_arm),
    .beg_a_i(rx_a_beg_i), .end_a_i(rx_a_end_i), .beg_b_i(rx_b_beg_i), .end_b_i(rx_b_end_i),
    .beat_i(rx_beat), .act_o(rx_act), .ptr_o(rx_ptr), .armed_o(rx_armed), .done_o(rx_done_o)
  );

  sdma_tx_path #(.DW(DW)) i_tx_path (
    .clk_i, .rst_ni, .flush_i(tx_rst), .act_i(tx_act),
    .req_o(tx_req), .gnt_i(tx_gnt), .rdata_i(mem_rdata_i), .beat_o(tx_beat),
    .valid_o(tx_valid_o), .data_o(tx_data_o), .ready_i(tx_ready_i)
  );

  sdma_rx_path #(.DW(DW)) i_rx_path (
    .clk_i, .rst_ni, .flush_i(rx_rst), .act_i(rx_act),
    .req_o(rx_req), .gnt_i(rx_gnt), .wdata_o(rx_wdata), .beat_o(rx_beat),
    .valid_i(rx_valid_i), .data_i(rx_data_i), .ready_o(rx_ready_o)
  );

  sdma_mem_arb #(.AW(AW), .DW(DW)) i_arb (
    .rx_req_i(rx_req), .rx_addr_i(rx_ptr), .rx_wdata_i(rx_wdata), .rx_gnt_o(rx_gnt),
    .tx_req_i(tx_req), .tx_addr_i(tx_ptr), .tx_gnt_o(tx_gnt),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_gnt_i
  );
endmodule

// File: rtl/sdma_checker.sv
module sdma_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_we_i,
  input logic [5:0]  ctrl_wdata_i,
  input logic [31:0] ctrl_rdata_o,
  input logic [1:0]  tx_done_o,
  input logic [1:0]  rx_done_o,
  input logic        tx_valid_o,
  input logic        rx_ready_o,
  input logic        tx_act_i,
  input logic        rx_act_i
);
  p_rsv_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rdata_o[31:4] == 28'd0);

  p_arm_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[2] && !ctrl_wdata_i[5] && !ctrl_rdata_o[2]) |=> ctrl_rdata_o[2]);

  p_tx_done_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_done_o));
  p_rx_done_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_done_o));
  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o[0] |=> !tx_done_o[0]);
  p_done_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o[0] |-> !ctrl_rdata_o[2]);

  p_tx_no_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_o[0] && ctrl_rdata_o[3]) |-> tx_act_i);
  p_rx_no_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_o[0] && ctrl_rdata_o[1]) |-> rx_act_i);

  p_tx_rst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[5]) |=> (ctrl_rdata_o[3:2] == 2'b00 && !tx_valid_o && !tx_act_i));
  p_rx_rst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[4]) |=> (ctrl_rdata_o[1:0] == 2'b00 && !rx_ready_o && !rx_act_i));
endmodule

bind serial_dma_ctrl sdma_checker i_sdma_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
  .ctrl_rdata_o(ctrl_rdata_o), .tx_done_o(tx_done_o), .rx_done_o(rx_done_o),
  .tx_valid_o(tx_valid_o), .rx_ready_o(rx_ready_o), .tx_act_i(tx_act), .rx_act_i(rx_act)
);

// File: tb/test_serial_dma_ctrl.sv
module test_serial_dma_ctrl;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          we = 1'b0;
  logic [5:0]    wd = '0;
  logic [31:0]   rd;
  logic [AW-1:0] txab = '0, txae = '0, txbb = '0, txbe = '0;
  logic [AW-1:0] rxab = '0, rxae = '0, rxbb = '0, rxbe = '0;
  logic          mreq, mwe, mgnt;
  logic [AW-1:0] maddr;
  logic [7:0]    mwd, mrd;
  logic          txv, rxr, rxv = 1'b0;
  logic          txr = 1'b0;
  logic [7:0]    txd, rxd = '0;
  logic [1:0]    txdn, rxdn;

  serial_dma_ctrl #(.AW(AW)) i_serial_dma_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wd), .ctrl_rdata_o(rd),
    .tx_a_beg_i(txab), .tx_a_end_i(txae), .tx_b_beg_i(txbb), .tx_b_end_i(txbe),
    .rx_a_beg_i(rxab), .rx_a_end_i(rxae), .rx_b_beg_i(rxbb), .rx_b_end_i(rxbe),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwd),
    .mem_gnt_i(mgnt), .mem_rdata_i(mrd),
    .tx_valid_o(txv), .tx_data_o(txd), .tx_ready_i(txr),
    .rx_valid_i(rxv), .rx_data_i(rxd), .rx_ready_o(rxr),
    .tx_done_o(txdn), .rx_done_o(rxdn)
  );

  int total = 0, bad = 0, cyc = 0;
  bit hold_off = 1'b0, tx_stall = 1'b0, mem_stall = 1'b0, ended = 1'b0;
  logic gnt_en = 1'b1;
  logic [7:0] mem [256];
  byte unsigned tx_q[$];
  int txd_q[$], rxd_q[$];

  // memory model: reads return a function of the address
  assign mgnt = mreq && gnt_en;
  assign mrd  = maddr[7:0] ^ 8'hA5;
  always @(posedge clk) if (mreq && mgnt && mwe) mem[maddr[7:0]] <= mwd;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor: drives ready and throttling, pops scoreboards
  always @(negedge clk) begin
    cyc++;
    gnt_en = mem_stall ? (cyc % 3 != 0) : 1'b1;
    txr = hold_off ? 1'b0 : (tx_stall ? cyc[1] : 1'b1);
    if (rst_n && txv && txr) begin
      if (tx_q.size() == 0) chk(0, "R5 unexpected tx byte", txd, 0);
      else begin
        byte unsigned e;
        e = tx_q.pop_front();
        chk(txd == e, "R5 tx byte order", txd, e);
      end
    end
    for (int b = 0; b < 2; b++) begin
      if (txdn[b]) begin
        if (txd_q.size() == 0) chk(0, "R3 unexpected tx done", b, -1);
        else begin
          int e;
          e = txd_q.pop_front();
          chk(b == e, "R4 tx done order", b, e);
        end
      end
      if (rxdn[b]) begin
        if (rxd_q.size() == 0) chk(0, "R3 unexpected rx done", b, -1);
        else begin
          int e;
          e = rxd_q.pop_front();
          chk(b == e, "R4 rx done order", b, e);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] v);
    @(negedge clk); we = 1'b1; wd = v;
    @(negedge clk); we = 1'b0; wd = '0;
  endtask

  task automatic push_tx(input int b, input int e);
    for (int a = b; a <= e; a++) tx_q.push_back(byte'(a[7:0] ^ 8'hA5));
  endtask

  task automatic wait_clear(input logic [31:0] mask, input string rq);
    int n = 0;
    while ((rd & mask) != 0 && n < 3000) begin @(negedge clk); n++; end
    chk((rd & mask) == 0, rq, rd, 0);
  endtask

  task automatic rx_send(input logic [7:0] v);
    @(negedge clk); rxv = 1'b1; rxd = v;
    while (!rxr) @(negedge clk);
    @(posedge clk);
    @(negedge clk); rxv = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd == 0, "R1 reset read value", rd, 0);
    chk(!txv && !rxr && !mreq, "R1 reset outputs idle", {txv, rxr, mreq}, 0);

    // single transmit buffer
    txab = 0; txae = 5;
    push_tx(0, 5); txd_q.push_back(0);
    wr(6'h04);
    chk(rd[2] == 1'b1, "R2 arm sets status", rd, 32'h4);
    wait_clear(32'hF, "R3 status clears on completion");

    // both armed together, throttled
    tx_stall = 1; mem_stall = 1;
    txab = 8; txae = 10; txbb = 32; txbe = 35;
    push_tx(8, 10); push_tx(32, 35); txd_q.push_back(0); txd_q.push_back(1);
    wr(6'h0C);
    chk(rd[3:2] == 2'b11, "R4 both armed", rd, 32'hC);
    wait_clear(32'hF, "R4 both completed");

    // queue B behind active A
    txab = 48; txae = 55; txbb = 60; txbe = 61;
    push_tx(48, 55); push_tx(60, 61); txd_q.push_back(0); txd_q.push_back(1);
    wr(6'h04);
    repeat (4) @(negedge clk);
    wr(6'h08);
    chk(rd[3:2] == 2'b11, "R8 idle B queued behind A", rd, 32'hC);
    wait_clear(32'hF, "R7 switch and finish");
    tx_stall = 0; mem_stall = 0;

    // re-arm of active buffer ignored
    hold_off = 1;
    txab = 16; txae = 19;
    push_tx(16, 19); txd_q.push_back(0);
    wr(6'h04);
    repeat (4) @(negedge clk);
    wr(6'h04);
    chk(rd[3:0] == 4'h4, "R8 re-arm leaves status", rd, 32'h4);
    // write of zero keeps status
    wr(6'h00);
    chk(rd[3:0] == 4'h4, "R2 zero write no effect", rd, 32'h4);
    hold_off = 0;
    wait_clear(32'hF, "R8 single run completes");
    repeat (20) @(negedge clk);
    chk(tx_q.size() == 0 && txd_q.size() == 0, "R8 no second run", tx_q.size(), 0);

    // receive, both armed
    rxab = 64; rxae = 67; rxbb = 80; rxbe = 81;
    rxd_q.push_back(0); rxd_q.push_back(1);
    wr(6'h03);
    mem_stall = 1;
    for (int i = 0; i < 6; i++) rx_send(8'h30 + 8'(i));
    wait_clear(32'hF, "R3 rx status clears");
    mem_stall = 0;
    for (int i = 0; i < 4; i++)
      chk(mem[64+i] == 8'h30 + 8'(i), "R6 rx buffer A content", mem[64+i], 8'h30 + i);
    for (int i = 0; i < 2; i++)
      chk(mem[80+i] == 8'h34 + 8'(i), "R6 rx buffer B content", mem[80+i], 8'h34 + i);

    // direction resets
    rxab = 100; rxae = 103;
    wr(6'h01);
    rx_send(8'h71); rx_send(8'h72);
    hold_off = 1;
    txab = 0; txae = 7;
    wr(6'h04);
    repeat (6) @(negedge clk);
    wr(6'h20);
    chk(rd[3:2] == 2'b00, "R9 tx reset clears arms", rd, 0);
    chk(!txv, "R9 tx byte discarded", txv, 0);
    chk(rd[0] == 1'b1, "R9 rx untouched by tx reset", rd, 1);
    chk(rd[5:4] == 2'b00, "R1 reset bits read zero", rd[5:4], 0);
    tx_q.delete(); txd_q.delete();
    hold_off = 0;
    wr(6'h10);
    chk(rd[1:0] == 2'b00 && !rxr, "R9 rx reset clears and stops", {rd[1:0], rxr}, 0);
    wr(6'h24);
    chk(rd[3:2] == 2'b00, "R9 reset wins over arm", rd, 0);
    rxae = 101;
    rxd_q.push_back(0);
    wr(6'h01);
    rx_send(8'h91); rx_send(8'h92);
    wait_clear(32'hF, "R9 rx restarts after reset");
    chk(mem[100] == 8'h91 && mem[101] == 8'h92, "R9 pointer restarts at start",
        {mem[100], mem[101]}, 16'h9192);
    repeat (10) @(negedge clk);
    chk(tx_q.size() == 0 && rxd_q.size() == 0 && txd_q.size() == 0,
        "R3 all expected events seen", tx_q.size() + rxd_q.size(), 0);

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule